// File: doc/BRIEF.md
# Repeated-Addition Unsigned Multiplier

This block multiplies two unsigned operands by adding the multiplicand into an accumulator as many times as the multiplier says. Both operands arrive one after the other on a single shared input bus. The product leaves on an output bus. The datapath holds three registers: the multiplicand, a multiplier that also serves as the loop count, and the accumulator. An adder forms the accumulator plus the multiplicand. A zero detector watches the loop count.

Sequencing comes from a 3-bit loadable counter followed by a 3-to-8 decoder, which gives six timing states. A two-term gate rule sets when the counter loads and what value it loads. After reset the block takes the multiplicand in the first state and the multiplier in the second. It then alternates between an add-and-decrement state and a test state until the count reaches zero. Next it presents the product for one cycle and parks in a stop state until the next reset. The product is kept modulo 2^W. Overflow and signed operands are not handled.

Top module: `seqadd_mult`

## Requirements
- R1: While reset is high, and in the first cycle after it is released, the block is in state T0. In that state `ctrl` equals 7'b0000011, `done` is 0 and `out_en` is 0.
- R2: The multiplicand is captured from `in_bus` at the clock edge that ends T0. The multiplier is captured at the edge that ends T1. The value of `in_bus` in any later cycle has no effect on the product.
- R3: `ctrl` bit i is control line Ci. The state-to-`ctrl` mapping is fixed: T0 gives bits 0 and 1, T1 gives bit 2, T2 gives bits 3, 4 and 6, T3 gives no bits, T4 gives bit 5, and T5 gives no bits.
- R4: The states run in the order T0, T1, T2, T3. In T3 the block returns to T2 when the count is non-zero and goes on to T4 when it is zero. With multiplier n ≥ 1, T4 is therefore reached 2+2n cycles after T0.
- R5: In T4, `out_en` is 1 and `out_bus` equals (multiplicand × multiplier) mod 2^W. `out_en` is 1 for exactly one cycle per run.
- R6: `out_bus` is all zeros whenever `out_en` is 0.
- R7: In T5, `done` is 1 and `ctrl` is all zeros. `done` stays at 1 until reset.
- R8: A multiplier of zero wraps the count and still passes through the add state. The block makes 2^W additions, reaches T4 2+2·2^W cycles after T0, and outputs 0.
- R9: Raising reset in any state returns the block to T0 at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous active-high reset of the sequence counter |
| in_bus | input | W | Shared operand bus: multiplicand in T0, multiplier in T1 |
| out_bus | output | W | Product while `out_en` is high, zero otherwise |
| out_en | output | 1 | High in T4, when the product is on `out_bus` |
| ctrl | output | 7 | Control lines C0..C6, bit i = Ci |
| done | output | 1 | High in the stop state T5 |

## Verification
The operand pairs are chosen to separate distinct failure modes. Small products such as 3×5 and 5×1 expose a loop that runs one pass too many or too few. Products that exceed 2^W, such as 7×6 and 15×15, show that the result wraps rather than saturates. A zero multiplicand gives a zero product even though the loop runs in full. A zero multiplier checks both the 2^W-pass wraparound and its cycle count. Every run checks the control vector cycle by cycle against the expected state walk. During the loop, the input bus is deliberately driven with changing garbage. A reset raised in the middle of a run confirms the return to T0.

// File: rtl/seqadd_mult.sv
module seqadd_mult #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] in_bus,
  output logic [W-1:0] out_bus,
  output logic         out_en,
  output logic [6:0]   ctrl,
  output logic         done
);
  localparam int SW = 3;
  localparam int NT = 1 << SW;

  logic [SW-1:0] sc;
  logic [SW-1:0] d;
  logic [NT-1:0] t;
  logic [W-1:0]  m, q, r, f;
  logic          z, ld, loop_back;

  assign t = NT'(1) << sc;

  assign ctrl[0] = t[0];
  assign ctrl[1] = t[0];
  assign ctrl[2] = t[1];
  assign ctrl[3] = t[2];
  assign ctrl[4] = t[2];
  assign ctrl[5] = t[4];
  assign ctrl[6] = t[2];

  assign z         = (q == '0);
  assign loop_back = ~z & t[3];
  assign ld        = loop_back | t[5];
  assign d         = {t[5], loop_back, t[5]};

  always_ff @(posedge clk or posedge rst) begin
    if (rst)     sc <= '0;
    else if (ld) sc <= d;
    else         sc <= sc + 1'b1;
  end

  assign f = r + m;

  always_ff @(posedge clk) begin
    if (ctrl[0])      r <= '0;
    else if (ctrl[6]) r <= f;
    if (ctrl[1])      m <= in_bus;
    if (ctrl[2])      q <= in_bus;
    else if (ctrl[4]) q <= q - 1'b1;
  end

  assign out_en  = ctrl[5];
  assign out_bus = out_en ? r : '0;
  assign done    = t[5];
endmodule

module seqadd_mult_chk #(
  parameter int W = 4
) (
  input logic         clk,
  input logic         rst,
  input logic [W-1:0] out_bus,
  input logic         out_en,
  input logic [6:0]   ctrl,
  input logic         done
);
  // R3
  ctrl_legal_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl inside {7'h03, 7'h04, 7'h58, 7'h00, 7'h20});
  // R4
  add_then_test_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl == 7'h58 |=> ctrl == 7'h00);
  // R4
  t1_after_t0_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl == 7'h03 |=> ctrl == 7'h04);
  // R5
  single_out_chk: assert property (@(posedge clk) disable iff (rst)
    out_en |=> !out_en && done);
  // R6
  bus_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !out_en |-> out_bus == '0);
  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> done);
  // R7
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> ctrl == 7'h00);
endmodule

bind seqadd_mult seqadd_mult_chk #(.W(W)) i_seqadd_mult_chk (
  .clk(clk), .rst(rst), .out_bus(out_bus), .out_en(out_en),
  .ctrl(ctrl), .done(done)
);

// File: tb/test_seqadd_mult.sv
module test_seqadd_mult;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] in_bus = '0;
  logic [W-1:0] out_bus;
  logic         out_en;
  logic [6:0]   ctrl;
  logic         done;

  int nchk = 0;
  int nfail = 0;

  seqadd_mult #(.W(W)) i_seqadd_mult (
    .clk(clk), .rst(rst), .in_bus(in_bus), .out_bus(out_bus),
    .out_en(out_en), .ctrl(ctrl), .done(done)
  );

  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_mult(input int mv, input int nv);
    int ne   = (nv == 0) ? (1 << W) : nv;
    int tout = 2 + 2 * ne;
    int prod = (mv * nv) % (1 << W);
    int expc;
    rst = 1'b1;
    in_bus = W'(mv);
    repeat (2) @(posedge clk);
    @(negedge clk);
    chk(ctrl == 7'h03, "R1 ctrl in reset", ctrl, 3);
    chk(done == 1'b0, "R1 done in reset", done, 0);
    chk(out_en == 1'b0, "R1 out_en in reset", out_en, 0);
    rst = 1'b0;
    for (int k = 0; k <= tout + 6; k++) begin
      if (k == 1) in_bus = W'(nv);
      else if (k >= 2) in_bus = W'(k * 7 + 3);
      if (k == 0) expc = 7'h03;
      else if (k == 1) expc = 7'h04;
      else if (k < tout) expc = (k % 2 == 0) ? 7'h58 : 7'h00;
      else if (k == tout) expc = 7'h20;
      else expc = 7'h00;
      chk(ctrl == expc, "R3 ctrl per state", ctrl, expc);
      if (k == tout) begin
        chk(out_en == 1'b1, (nv == 0) ? "R8 out_en timing" : "R4 out_en timing", out_en, 1);
        chk(out_bus == W'(prod), (nv == 0) ? "R8 zero-multiplier product" : "R2 R5 product",
            out_bus, prod);
      end else begin
        chk(out_en == 1'b0, "R5 out_en single cycle", out_en, 0);
        chk(out_bus == '0, "R6 out_bus quiet", out_bus, 0);
      end
      chk(done == (k > tout), "R7 done", done, int'(k > tout));
      @(negedge clk);
    end
  endtask

  task automatic mid_reset;
    rst = 1'b1;
    in_bus = W'(9);
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    in_bus = W'(9);
    @(negedge clk);
    in_bus = W'(4);
    repeat (4) @(negedge clk);
    rst = 1'b1;
    #1;
    chk(ctrl == 7'h03, "R9 ctrl after mid-run reset", ctrl, 3);
    chk(out_en == 1'b0, "R9 out_en after mid-run reset", out_en, 0);
    chk(done == 1'b0, "R9 done after mid-run reset", done, 0);
  endtask

  initial begin
    #(8 * 200000);
    nfail++;
    $display("FAIL R4 watchdog got running expected finished");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    run_mult(3, 5);
    run_mult(7, 6);
    run_mult(15, 15);
    run_mult(5, 1);
    run_mult(0, 9);
    run_mult(6, 0);
    mid_reset();
    run_mult(2, 7);
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule